// File: doc/BRIEF.md
# Big-Endian Aligned Memory Operand Sequencer

This block sits between a processor core and a byte-addressable memory that has a 16-bit data path. The core hands it one operand request at a time: an address, a size code (byte, word or long word), a direction, and write data for stores. The block turns that request into one or two memory bus cycles. Each bus cycle holds its address, byte strobes and write data until the memory answers with ready.

Operands are big-endian. The address of a multi-byte operand names its most significant byte. A long word at address N is carried as two word cycles: the more significant half at N, then the less significant half at N+2. A byte at an even address travels on the upper lane [15:8], and a byte at an odd address travels on the lower lane [7:0].

Word and long-word operands must start on an even address. A request that breaks this rule, or that uses the reserved size code, is refused. The block raises an address-error flag together with done and starts no bus cycle. For any request it takes, the block pulses done exactly once, when the whole operand has moved. Read data arrives zero-extended in the low bits of a 32-bit result.

Top module: `be_operand_seq`

## Requirements
- R1: Size code 2'b00 is a byte. A byte at an even address uses strobe pattern mem_be=2'b10 (bit 1 enables lane [15:8]). A byte at an odd address uses mem_be=2'b01 (bit 0 enables lane [7:0]). Write data req_wdata[7:0] is driven on both lanes. A byte read returns the selected lane in rdata[7:0], with rdata[31:8] zero.
- R2: Size code 2'b01 is a word. A word at an even address makes exactly one bus cycle at that address with mem_be=2'b11. mem_wdata carries req_wdata[15:0]. mem_rdata[15:8] is the byte at the operand address. rdata holds the word in [15:0], with rdata[31:16] zero.
- R3: Size code 2'b10 is a long word. A long word at an even address N makes exactly two bus cycles, first at N and then at N+2, both with mem_be=2'b11. The first cycle writes req_wdata[31:16] and the second writes req_wdata[15:0]. A read returns {first cycle data, second cycle data}.
- R4: done is high for exactly one cycle per accepted request. For a request that completes, that cycle is the one after the edge on which the final bus cycle sees mem_ready high.
- R5: A word or long request with address bit 0 set produces done and addr_err together in the cycle after the request. It starts no bus cycle and changes no memory byte.
- R6: Size code 2'b11 is reserved. At any address it is refused in the same way as R5.
- R7: While mem_req is high and mem_ready is low, mem_addr, mem_we, mem_be and mem_wdata keep their values, and mem_req stays high into the next cycle.
- R8: A req_valid seen while a transfer is in progress is ignored. It adds no bus cycle, no done pulse and no memory change.
- R9: After reset, mem_req, done and addr_err are low.
- R10: addr_err is low on the done pulse of a request that completed its bus cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request strobe, taken when no transfer is in progress |
| req_addr | input | ADDR_W | Byte address of the operand's most significant byte |
| req_size | input | 2 | 00 byte, 01 word, 10 long word, 11 reserved |
| req_write | input | 1 | 1 store, 0 load |
| req_wdata | input | 32 | Store data, right-aligned by size |
| rdata | output | 32 | Load result, zero-extended, valid with done |
| done | output | 1 | One-cycle completion pulse |
| addr_err | output | 1 | Set with done when the request was refused |
| mem_req | output | 1 | Bus cycle active |
| mem_addr | output | ADDR_W | Bus cycle byte address (even for word cycles) |
| mem_we | output | 1 | Bus cycle is a write |
| mem_be | output | 2 | Lane strobes, bit 1 = [15:8], bit 0 = [7:0] |
| mem_wdata | output | 16 | Bus write data |
| mem_rdata | input | 16 | Bus read data, sampled with mem_ready |
| mem_ready | input | 1 | Memory completes the current bus cycle |

## Verification
The bench sends byte requests at even and odd addresses. Each sets a distinct byte to a distinct value, so a swapped lane or a wrong strobe shows up as a wrong neighbour byte or a wrong result. Word and long requests at even addresses check the byte order inside each word and the order of the two long-word halves. Long words whose address has bit 1 set check the carry into N+2. Misaligned word and long requests, and the reserved size, must yield the error pulse with no bus cycle. A request injected during a stalled long read must leave the beat count and memory untouched. The memory model inserts random wait states, which exercises the hold-until-ready rule.

// File: rtl/opseq_pkg.sv
package opseq_pkg;
  localparam int BUS_W = 16;
  localparam int OPD_W = 32;
  localparam int LANES = BUS_W / 8;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'b00,
    SZ_WORD = 2'b01,
    SZ_LONG = 2'b10,
    SZ_RSVD = 2'b11
  } opsize_e;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'b00,
    ST_FIRST  = 2'b01,
    ST_SECOND = 2'b10
  } seq_state_e;

  // refused: reserved size, or multi-byte operand on an odd address
  function automatic logic refuse_req(opsize_e sz, logic a0);
    return (sz == SZ_RSVD) || ((sz != SZ_BYTE) && a0);
  endfunction

  // lane strobes for one bus cycle; bit 1 = upper lane
  function automatic logic [LANES-1:0] beat_strobe(opsize_e sz, logic a0);
    if (sz == SZ_BYTE) return a0 ? 2'b01 : 2'b10;
    return 2'b11;
  endfunction

  // write data for one bus cycle
  function automatic logic [BUS_W-1:0] beat_wdata(opsize_e sz, logic second,
                                                  logic [OPD_W-1:0] wd);
    if (sz == SZ_BYTE) return {wd[7:0], wd[7:0]};
    if (sz == SZ_LONG && !second) return wd[OPD_W-1:BUS_W];
    return wd[BUS_W-1:0];
  endfunction

  // assemble load result from last bus data and captured high half
  function automatic logic [OPD_W-1:0] pack_read(opsize_e sz, logic a0,
                                                 logic [BUS_W-1:0] hi,
                                                 logic [BUS_W-1:0] d);
    case (sz)
      SZ_BYTE: return {24'h0, (a0 ? d[7:0] : d[15:8])};
      SZ_WORD: return {16'h0, d};
      default: return {hi, d};
    endcase
  endfunction
endpackage

// File: rtl/opseq_align.sv
module opseq_align
  import opseq_pkg::*;
(
  input  logic [1:0] size,
  input  logic       addr_lsb,
  output logic       refuse
);
  always_comb refuse = refuse_req(opsize_e'(size), addr_lsb);
endmodule

// File: rtl/opseq_steer.sv
module opseq_steer
  import opseq_pkg::*;
#(
  parameter int ADDR_W = 24
) (
  input  logic [ADDR_W-1:0] base_addr,
  input  logic [1:0]        size,
  input  logic              second,
  input  logic [OPD_W-1:0]  wdata,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [LANES-1:0]  bus_be,
  output logic [BUS_W-1:0]  bus_wdata
);
  localparam logic [ADDR_W-1:0] WORD_STEP = ADDR_W'(LANES);

  always_comb begin
    bus_addr  = second ? (base_addr + WORD_STEP) : base_addr;
    bus_be    = beat_strobe(opsize_e'(size), base_addr[0]);
    bus_wdata = beat_wdata(opsize_e'(size), second, wdata);
  end
endmodule

// File: rtl/opseq_ctrl.sv
module opseq_ctrl
  import opseq_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic is_long,
  input  logic ready,
  output logic active,
  output logic second,
  output logic first_hit,
  output logic last_hit
);
  seq_state_e state_q, state_d;

  always_comb begin
    active    = (state_q != ST_IDLE);
    second    = (state_q == ST_SECOND);
    first_hit = ready && (state_q == ST_FIRST);
    last_hit  = ready && ((state_q == ST_SECOND) ||
                          (state_q == ST_FIRST && !is_long));
    state_d = state_q;
    case (state_q)
      ST_IDLE:   if (start) state_d = ST_FIRST;
      ST_FIRST:  if (ready) state_d = is_long ? ST_SECOND : ST_IDLE;
      ST_SECOND: if (ready) state_d = ST_IDLE;
      default:   state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end
endmodule

// File: rtl/be_operand_seq.sv
module be_operand_seq
  import opseq_pkg::*;
#(
  parameter int ADDR_W = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [1:0]        req_size,
  input  logic              req_write,
  input  logic [31:0]       req_wdata,
  output logic [31:0]       rdata,
  output logic              done,
  output logic              addr_err,
  output logic              mem_req,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_we,
  output logic [1:0]        mem_be,
  output logic [15:0]       mem_wdata,
  input  logic [15:0]       mem_rdata,
  input  logic              mem_ready
);
  logic              busy, in_second, first_hit, last_hit;
  logic              refuse, accept, fault_hit, launch;
  logic [ADDR_W-1:0] addr_q;
  logic [1:0]        size_q;
  logic              we_q;
  logic [OPD_W-1:0]  wdata_q;
  logic [BUS_W-1:0]  hi_q;
  logic [OPD_W-1:0]  rdata_q;
  logic              done_q, err_q;

  // named events for the checker
  assign accept    = req_valid && !busy;
  assign fault_hit = accept && refuse;
  assign launch    = accept && !refuse;

  opseq_align u_align (
    .size     (req_size),
    .addr_lsb (req_addr[0]),
    .refuse   (refuse)
  );

  opseq_ctrl u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (launch),
    .is_long   (size_q == SZ_LONG),
    .ready     (mem_ready),
    .active    (busy),
    .second    (in_second),
    .first_hit (first_hit),
    .last_hit  (last_hit)
  );

  opseq_steer #(.ADDR_W(ADDR_W)) u_steer (
    .base_addr (addr_q),
    .size      (size_q),
    .second    (in_second),
    .wdata     (wdata_q),
    .bus_addr  (mem_addr),
    .bus_be    (mem_be),
    .bus_wdata (mem_wdata)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q  <= '0;
      size_q  <= SZ_BYTE;
      we_q    <= 1'b0;
      wdata_q <= '0;
    end else if (launch) begin
      addr_q  <= req_addr;
      size_q  <= req_size;
      we_q    <= req_write;
      wdata_q <= req_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hi_q <= '0;
    else if (first_hit && size_q == SZ_LONG) hi_q <= mem_rdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_q  <= 1'b0;
      err_q   <= 1'b0;
      rdata_q <= '0;
    end else begin
      done_q <= fault_hit || last_hit;
      err_q  <= fault_hit;
      if (last_hit)
        rdata_q <= we_q ? '0 : pack_read(opsize_e'(size_q), addr_q[0], hi_q, mem_rdata);
    end
  end

  assign mem_req  = busy;
  assign mem_we   = we_q;
  assign rdata    = rdata_q;
  assign done     = done_q;
  assign addr_err = err_q;
endmodule

// File: rtl/opseq_checker.sv
module opseq_checker #(
  parameter int ADDR_W = 24
) (
  input logic              clk,
  input logic              rst_n,
  input logic              fault_hit,
  input logic              mem_req,
  input logic              mem_ready,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              mem_we,
  input logic [1:0]        mem_be,
  input logic [15:0]       mem_wdata,
  input logic              done,
  input logic              addr_err
);
  AST_HOLD_UNTIL_READY: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ready) |=> (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_be) && $stable(mem_wdata))); // R7
  AST_REFUSE_NO_BUS: assert property (@(posedge clk) disable iff (!rst_n)
    fault_hit |=> (!mem_req && done && addr_err)); // R5
  AST_ERR_NEEDS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    addr_err |-> done); // R10
  AST_WORD_EVEN: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_be == 2'b11) |-> !mem_addr[0]); // R2
  AST_BYTE_LANE: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && $countones(mem_be) == 1) |-> (mem_be[1] == !mem_addr[0])); // R1
  AST_STROBE_SET: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> (mem_be != 2'b00)); // R3
endmodule

bind be_operand_seq opseq_checker #(.ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .fault_hit (fault_hit),
  .mem_req   (mem_req),
  .mem_ready (mem_ready),
  .mem_addr  (mem_addr),
  .mem_we    (mem_we),
  .mem_be    (mem_be),
  .mem_wdata (mem_wdata),
  .done      (done),
  .addr_err  (addr_err)
);

// File: tb/sim_be_operand_seq.sv
module sim_be_operand_seq;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [1:0]    req_size = 2'b00;
  logic          req_write = 1'b0;
  logic [31:0]   req_wdata = '0;
  logic [31:0]   rdata;
  logic          done, addr_err, mem_req, mem_we;
  logic [AW-1:0] mem_addr;
  logic [1:0]    mem_be;
  logic [15:0]   mem_wdata;
  logic [15:0]   mem_rdata = '0;
  logic          mem_ready = 1'b0;

  int checks = 0;
  int errors = 0;

  logic [7:0]    mem   [256];
  logic [7:0]    shadow[256];
  int            beat_n = 0;
  logic [AW-1:0] beat_addr[8];
  logic [1:0]    beat_be[8];
  int            stall_left = 0;
  logic          prev_wait = 1'b0;
  logic [AW-1:0] p_addr;
  logic [1:0]    p_be;
  logic [15:0]   p_wdata;
  logic          p_we;

  always #(CLK_PERIOD/2) clk = ~clk;

  be_operand_seq #(.ADDR_W(AW)) u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
    .req_size(req_size), .req_write(req_write), .req_wdata(req_wdata),
    .rdata(rdata), .done(done), .addr_err(addr_err), .mem_req(mem_req),
    .mem_addr(mem_addr), .mem_we(mem_we), .mem_be(mem_be),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ready(mem_ready)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // memory model: decides ready at the falling edge, DUT samples at the rising edge
  always @(negedge clk) begin
    if (prev_wait)
      check(mem_req && mem_addr == p_addr && mem_be == p_be &&
            mem_wdata == p_wdata && mem_we == p_we, "R7 hold", {16'h0, mem_addr}, {16'h0, p_addr});
    if (mem_req) begin
      logic       rdy;
      logic [7:0] a;
      a = mem_addr[7:0];
      if (stall_left > 0) begin rdy = 1'b0; stall_left--; end
      else rdy = ($urandom % 3) != 0;
      mem_rdata = {mem[{a[7:1], 1'b0}], mem[{a[7:1], 1'b1}]};
      if (rdy) begin
        if (beat_n < 8) begin beat_addr[beat_n] = mem_addr; beat_be[beat_n] = mem_be; end
        beat_n++;
        if (mem_we) begin
          if (mem_be[1]) mem[{a[7:1], 1'b0}] = mem_wdata[15:8];
          if (mem_be[0]) mem[{a[7:1], 1'b1}] = mem_wdata[7:0];
        end
      end
      mem_ready = rdy;
      prev_wait = !rdy;
      p_addr = mem_addr; p_be = mem_be; p_wdata = mem_wdata; p_we = mem_we;
    end else begin
      mem_ready = 1'b0;
      prev_wait = 1'b0;
    end
  end

  function automatic int nbytes(input logic [1:0] sz);
    return (sz == 2'b00) ? 1 : (sz == 2'b01) ? 2 : 4;
  endfunction

  function automatic logic [31:0] ref_read(input logic [7:0] a, input logic [1:0] sz);
    logic [31:0] v = '0;
    for (int i = 0; i < nbytes(sz); i++) v = {v[23:0], shadow[a + 8'(i)]};
    return v;
  endfunction

  task automatic ref_write(input logic [7:0] a, input logic [1:0] sz, input logic [31:0] wd);
    int n = nbytes(sz);
    for (int i = 0; i < n; i++) shadow[a + 8'(i)] = wd[8*(n-1-i) +: 8];
  endtask

  task automatic mem_compare(input string req);
    int bad = 0;
    for (int i = 0; i < 256; i++) if (mem[i] !== shadow[i]) bad++;
    check(bad == 0, req, 32'(bad), 32'h0);
  endtask

  task automatic do_op(input logic [AW-1:0] a, input logic [1:0] sz,
                       input logic wr, input logic [31:0] wd);
    logic        refuse;
    logic [31:0] exp_r;
    int          cyc;
    string       tg;
    refuse = (sz == 2'b11) || (sz != 2'b00 && a[0]);
    tg = (sz == 2'b11) ? "R6" : refuse ? "R5" : (sz == 2'b00) ? "R1" : (sz == 2'b01) ? "R2" : "R3";
    exp_r = ref_read(a[7:0], sz);
    @(negedge clk);
    beat_n = 0;
    req_valid = 1'b1; req_addr = a; req_size = sz; req_write = wr; req_wdata = wd;
    @(negedge clk);
    req_valid = 1'b0;
    cyc = 0;
    while (!done && cyc < 60) begin @(negedge clk); cyc++; end
    check(done, "R4 done seen", 32'(done), 32'h1);
    check(addr_err == refuse, refuse ? tg : "R10", 32'(addr_err), 32'(refuse));
    if (refuse) begin
      check(cyc == 0, "R5 error latency", 32'(cyc), 32'h0);
      check(beat_n == 0, {tg, " no bus cycle"}, 32'(beat_n), 32'h0);
    end else begin
      if (wr) ref_write(a[7:0], sz, wd);
      else    check(rdata == exp_r, {tg, " read data"}, rdata, exp_r);
      check(beat_n == ((sz == 2'b10) ? 2 : 1), {tg, " beat count"}, 32'(beat_n), 32'(sz == 2'b10 ? 2 : 1));
      check(beat_addr[0] == a, {tg, " first address"}, 32'(beat_addr[0]), 32'(a));
      check(beat_be[0] == ((sz == 2'b00) ? (a[0] ? 2'b01 : 2'b10) : 2'b11),
            {tg, " strobes"}, 32'(beat_be[0]), 32'h0);
      if (sz == 2'b10)
        check(beat_addr[1] == a + 16'd2, "R3 second address", 32'(beat_addr[1]), 32'(a + 16'd2));
    end
    mem_compare({tg, " memory"});
    @(negedge clk);
    check(!done, "R4 single pulse", 32'(done), 32'h0);
  endtask

  initial begin
    #(CLK_PERIOD * 190000);
    errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_0042));
    for (int i = 0; i < 256; i++) begin
      mem[i] = 8'(i * 7 + 3);
      shadow[i] = mem[i];
    end
    repeat (3) @(negedge clk);
    check(!mem_req && !done && !addr_err, "R9 reset state",
          {29'h0, mem_req, done, addr_err}, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    check(!mem_req && !done && !addr_err, "R9 after release",
          {29'h0, mem_req, done, addr_err}, 32'h0);

    // directed corner cases
    do_op(16'h0010, 2'b00, 1'b1, 32'h0000_00A5);  // R1 even byte write
    do_op(16'h0011, 2'b00, 1'b1, 32'h0000_005A);  // R1 odd byte write
    do_op(16'h0010, 2'b00, 1'b0, 32'h0);          // R1 even byte read
    do_op(16'h0011, 2'b00, 1'b0, 32'h0);          // R1 odd byte read
    do_op(16'h0020, 2'b01, 1'b1, 32'h0000_BEEF);  // R2
    do_op(16'h0020, 2'b01, 1'b0, 32'h0);
    do_op(16'h0032, 2'b10, 1'b1, 32'h1234_5678);  // R3 carry into bit 2
    do_op(16'h0032, 2'b10, 1'b0, 32'h0);
    do_op(16'h0041, 2'b01, 1'b1, 32'h0000_FFFF);  // R5 odd word
    do_op(16'h0043, 2'b10, 1'b0, 32'h0);          // R5 odd long
    do_op(16'h0044, 2'b11, 1'b1, 32'hFFFF_FFFF);  // R6 reserved size, even
    do_op(16'h0045, 2'b11, 1'b0, 32'h0);          // R6 reserved size, odd

    // R8: request injected during a stalled long read
    begin
      logic [31:0] exp_r;
      int cyc, dones;
      exp_r = ref_read(8'h60, 2'b10);
      @(negedge clk);
      beat_n = 0; stall_left = 4;
      req_valid = 1'b1; req_addr = 16'h0060; req_size = 2'b10; req_write = 1'b0; req_wdata = '0;
      @(negedge clk);
      req_addr = 16'h0071; req_size = 2'b00; req_write = 1'b1; req_wdata = 32'h0000_00C3;
      @(negedge clk);
      @(negedge clk);
      req_valid = 1'b0;
      cyc = 0; dones = 0;
      while (cyc < 40) begin
        if (done) dones++;
        @(negedge clk); cyc++;
      end
      check(dones == 1, "R8 one done", 32'(dones), 32'h1);
      check(beat_n == 2, "R8 beat count", 32'(beat_n), 32'h2);
      check(rdata == exp_r, "R8 read data", rdata, exp_r);
      mem_compare("R8 memory untouched");
    end

    // constrained random mix
    for (int n = 0; n < 300; n++) begin
      logic [AW-1:0] a;
      logic [1:0]    sz;
      a  = AW'($urandom % 240);
      sz = 2'($urandom % 4);
      if (($urandom % 4) != 0 && sz != 2'b00) a[0] = 1'b0;
      do_op(a, sz, 1'($urandom % 2), $urandom);
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule